// File: doc/BRIEF.md
# Radio Core Operating Mode Sequencer

This block is the mode controller of a packet radio's digital core. It places the core in one of six modes: powered down, standby-I (idle, low power), standby-II (transmitter ready, waiting for data), RX settling, active RX and TX. It works from the chip-enable pin, the power-up and primary-receive configuration bits, an empty flag from the transmit FIFO and a packet-done strobe from the transmit datapath. It reports the current mode and drives a one-cycle transmit-start strobe to the transmit datapath. It also drives a listening enable to the receive datapath. When a transmission runs too long, it raises a fault flag that stays set.

All microsecond intervals are fixed at compile time as cycle counts. These are the minimum chip-enable width before a transmission may start, the receiver settling time and the longest time allowed in TX. The defaults are derived from a clock-frequency parameter.

Mode codes on `mode`: powered down = 0, standby-I = 1, standby-II = 2, RX settling = 3, active RX = 4, TX = 5.

The named states are PDN, SB1, SB2, RXS, RXA and TX. The named transitions are:
- wake: PDN to SB1.
- rx_go: SB1 or SB2 to RXS.
- settle_end: RXS to RXA.
- rx_stop: RXS or RXA to SB1.
- tx_go: SB1 or SB2 to TX.
- next_pkt: TX to TX.
- tx_idle: TX to SB1.
- tx_park: TX to SB2.
- park_stop: SB2 to SB1.
- tx_abort: TX to SB1 on a timeout.
- sleep: any state to PDN.

Top module: `trx_mode_ctrl`

## Requirements
- R1: While reset is asserted, `mode` is 0 (powered down) and `tx_start`, `rx_listen` and `tx_fault` are 0.
- R2: With `pwr_up` low, `mode` is 0 after the next clock edge from any state, and `tx_fault` is cleared. With `pwr_up` high, powered down moves to standby-I (1) on the next edge. Power-down also resets every timer, so chip-enable must qualify again after power-up.
- R3: Standby-I moves to TX (5) only when `prim_rx` is low, `txf_empty` is low, and `ce` has been sampled high on CE_MIN_CYC consecutive edges. A pulse of CE_MIN_CYC-1 edges starts nothing. A qualified pulse with an empty FIFO waits in standby-I until the FIFO fills.
- R4: `tx_start` is high for exactly the first cycle of each packet in TX and is low at all other times.
- R5: Once in TX, the mode stays TX until `pkt_done` arrives, whatever `ce` and `txf_empty` do in the meantime. The only exceptions are the timeout (R11) and power-down.
- R6: When `pkt_done` arrives with `ce` low, the next mode is standby-I.
- R7: When `pkt_done` arrives with `ce` high, `txf_empty` low and `prim_rx` low, the mode stays TX and a new `tx_start` is issued.
- R8: When `pkt_done` arrives with `ce` high and `txf_empty` high, the next mode is standby-II (2). From standby-II, a non-empty FIFO with `ce` still high re-enters TX without a new chip-enable pulse, and `ce` low returns to standby-I.
- R9: In standby-I or standby-II, `ce` high with `prim_rx` high enters RX settling (3). RX settling lasts exactly RX_SETTLE_CYC cycles and is followed by active RX (4). `rx_listen` is high exactly while in active RX.
- R10: `ce` low during RX settling or active RX returns to standby-I on the next edge.
- R11: If TX_LIMIT_CYC cycles pass in TX without `pkt_done`, the block moves to standby-I and sets `tx_fault`, which stays set until power-down. A fresh chip-enable qualification is then required before TX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip-enable pin level |
| pwr_up | input | 1 | Power-up configuration bit |
| prim_rx | input | 1 | Primary-receive configuration bit |
| txf_empty | input | 1 | Transmit FIFO holds no payload |
| pkt_done | input | 1 | One-cycle strobe: current packet finished transmitting |
| mode | output | 3 | Current mode code (0..5) |
| tx_start | output | 1 | One-cycle strobe at the start of each packet |
| rx_listen | output | 1 | Receiver monitoring enable |
| tx_fault | output | 1 | Sticky TX time-limit fault |

## Verification
The bench sweeps the chip-enable pulse width from one to six edges around a four-edge threshold. A controller with an off-by-one qualifier would start TX one pulse early or never reach TX at the boundary. It measures the settling and TX-limit intervals cycle by cycle, which exposes a timer that ends a cycle early or late or never fires. It drives every combination of chip-enable level and FIFO state when a packet completes, so a wrong standby choice, a missing restart strobe or a TX exit before `pkt_done` shows up at `mode` and `tx_start`. It also checks that power-down and the timeout clear the chip-enable qualification: a design that kept the old count would re-enter TX immediately.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;

    typedef enum logic [2:0] {
        TRX_PDN = 3'd0,
        TRX_SB1 = 3'd1,
        TRX_SB2 = 3'd2,
        TRX_RXS = 3'd3,
        TRX_RXA = 3'd4,
        TRX_TX  = 3'd5
    } trx_mode_t;

endpackage

// File: rtl/trx_ce_qualifier.sv
// Counts consecutive edges with chip-enable high; armed once MIN_CYC reached.
module trx_ce_qualifier #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ce,
    output logic armed
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr || !ce) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(MIN_CYC)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign armed = (run_cnt == CW'(MIN_CYC));
endmodule

// File: rtl/trx_interval_timer.sv
// Counts cycles while not cleared; done in the LIMIT-th cycle after clear drops.
module trx_interval_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (clr) begin
            elapsed <= '0;
        end else if (elapsed != CW'(LIMIT - 1)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign done = !clr && (elapsed == CW'(LIMIT - 1));
endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
    import trx_mode_pkg::*;
#(
    parameter int CLK_MHZ       = 100,
    parameter int CE_MIN_CYC    = CLK_MHZ * 10 + 1,
    parameter int RX_SETTLE_CYC = CLK_MHZ * 130,
    parameter int TX_LIMIT_CYC  = CLK_MHZ * 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       pwr_up,
    input  logic       prim_rx,
    input  logic       txf_empty,
    input  logic       pkt_done,
    output logic [2:0] mode,
    output logic       tx_start,
    output logic       rx_listen,
    output logic       tx_fault
);
    trx_mode_t state, nxt;
    logic      ce_armed, settle_done, wd_done;
    logic      wd_fire, restart;

    trx_ce_qualifier #(.MIN_CYC(CE_MIN_CYC)) u_ceq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pwr_up || wd_fire),
        .ce    (ce),
        .armed (ce_armed)
    );

    trx_interval_timer #(.LIMIT(RX_SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != TRX_RXS),
        .done  (settle_done)
    );

    trx_interval_timer #(.LIMIT(TX_LIMIT_CYC)) u_txwd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != TRX_TX || pkt_done),
        .done  (wd_done)
    );

    always_comb begin
        nxt     = state;
        wd_fire = 1'b0;
        restart = 1'b0;
        if (!pwr_up) begin
            nxt = TRX_PDN;                              // sleep
        end else begin
            unique case (state)
                TRX_PDN: nxt = TRX_SB1;                 // wake
                TRX_SB1: begin
                    if (ce && prim_rx)
                        nxt = TRX_RXS;                  // rx_go
                    else if (!prim_rx && ce_armed && !txf_empty)
                        nxt = TRX_TX;                   // tx_go
                end
                TRX_SB2: begin
                    if (!ce)
                        nxt = TRX_SB1;                  // park_stop
                    else if (prim_rx)
                        nxt = TRX_RXS;                  // rx_go
                    else if (!txf_empty)
                        nxt = TRX_TX;                   // tx_go
                end
                TRX_RXS: begin
                    if (!ce)
                        nxt = TRX_SB1;                  // rx_stop
                    else if (settle_done)
                        nxt = TRX_RXA;                  // settle_end
                end
                TRX_RXA: begin
                    if (!ce)
                        nxt = TRX_SB1;                  // rx_stop
                end
                TRX_TX: begin
                    if (pkt_done) begin
                        if (!ce) begin
                            nxt = TRX_SB1;              // tx_idle
                        end else if (txf_empty || prim_rx) begin
                            nxt = TRX_SB2;              // tx_park
                        end else begin
                            nxt     = TRX_TX;           // next_pkt
                            restart = 1'b1;
                        end
                    end else if (wd_done) begin
                        nxt     = TRX_SB1;              // tx_abort
                        wd_fire = 1'b1;
                    end
                end
                default: nxt = TRX_PDN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= TRX_PDN;
        else
            state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_start  <= 1'b0;
            rx_listen <= 1'b0;
            tx_fault  <= 1'b0;
        end else begin
            tx_start  <= (nxt == TRX_TX) && ((state != TRX_TX) || restart);
            rx_listen <= (nxt == TRX_RXA);
            tx_fault  <= pwr_up && (tx_fault || wd_fire);
        end
    end

    assign mode = state;
endmodule

// File: rtl/trx_mode_ctrl_chk.sv
module trx_mode_ctrl_chk
    import trx_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce,
    input logic       pwr_up,
    input logic       pkt_done,
    input logic [2:0] mode,
    input logic       tx_start,
    input logic       rx_listen,
    input logic       tx_fault
);
    // R2
    sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> (mode == TRX_PDN) && !tx_fault);

    // R4
    start_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRX_TX && $past(mode) != TRX_TX) |-> tx_start);

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRX_TX && !pkt_done && pwr_up) |=> (mode == TRX_TX) || $rose(tx_fault));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRX_TX && pkt_done && !ce && pwr_up) |=> (mode == TRX_SB1));

    // R9
    listen_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_listen) |-> ($past(mode) == TRX_RXS));

    // R10
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == TRX_RXS || mode == TRX_RXA) && !ce && pwr_up) |=> (mode == TRX_SB1) && !rx_listen);

    // R11
    fault_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_fault) |-> ($past(mode) == TRX_TX) && (mode == TRX_SB1));
endmodule

bind trx_mode_ctrl trx_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .pwr_up    (pwr_up),
    .pkt_done  (pkt_done),
    .mode      (mode),
    .tx_start  (tx_start),
    .rx_listen (rx_listen),
    .tx_fault  (tx_fault)
);

// File: tb/trx_mode_ctrl_test.sv
`timescale 1ns/1ps
module trx_mode_ctrl_test;
    localparam int CEMIN  = 4;
    localparam int SETTLE = 6;
    localparam int LIMIT  = 20;

    logic       clk = 1'b0;
    logic       rst_n, ce, pwr_up, prim_rx, txf_empty, pkt_done;
    logic [2:0] mode;
    logic       tx_start, rx_listen, tx_fault;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    trx_mode_ctrl #(
        .CE_MIN_CYC(CEMIN), .RX_SETTLE_CYC(SETTLE), .TX_LIMIT_CYC(LIMIT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .pwr_up(pwr_up), .prim_rx(prim_rx),
        .txf_empty(txf_empty), .pkt_done(pkt_done), .mode(mode),
        .tx_start(tx_start), .rx_listen(rx_listen), .tx_fault(tx_fault)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_mode(input int m);
        for (int i = 0; i < 50 && mode != 3'(m); i++) tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 0; ce = 0; pwr_up = 0; prim_rx = 0; txf_empty = 1; pkt_done = 0;
        tick(); tick(); pwr_up = 1; tick();
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 outputs", {tx_start, rx_listen, tx_fault}, 0);
        rst_n = 1; tick();
        chk("R2 wake", mode, 1);

        // R3 pulse width sweep
        txf_empty = 0;
        for (int w = 1; w <= 6; w++) begin
            ce = 1;
            repeat (w) tick();
            ce = 0; tick();
            chk($sformatf("R3 width %0d", w), mode, (w >= CEMIN) ? 5 : 1);
            if (w >= CEMIN) begin
                pkt_done = 1; tick(); pkt_done = 0;
                chk("R6 done ce low", mode, 1);
            end else begin
                tick(); tick();
                chk("R3 short pulse idle", mode, 1);
            end
        end

        // R3 empty FIFO holds in standby-I
        txf_empty = 1; ce = 1;
        repeat (8) tick();
        chk("R3 empty fifo", mode, 1);
        txf_empty = 0; tick();
        chk("R3 fifo fills", mode, 5);
        ce = 0; pkt_done = 1; tick(); pkt_done = 0;
        chk("R6 idle", mode, 1);

        // R4 strobe timing
        ce = 1;
        repeat (CEMIN) tick();
        chk("R4 before entry mode", mode, 1);
        chk("R4 before entry strobe", tx_start, 0);
        tick();
        chk("R4 entry mode", mode, 5);
        chk("R4 entry strobe", tx_start, 1);
        tick();
        chk("R4 strobe single", tx_start, 0);

        // R5 hold in TX
        ce = 0; txf_empty = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 hold", mode, 5);
        end

        // R7 back-to-back
        ce = 1; txf_empty = 0; pkt_done = 1; tick(); pkt_done = 0;
        chk("R7 stay", mode, 5);
        chk("R7 restart strobe", tx_start, 1);
        tick();
        chk("R7 strobe drops", tx_start, 0);

        // R8 standby-II
        txf_empty = 1; pkt_done = 1; tick(); pkt_done = 0;
        chk("R8 park", mode, 2);
        chk("R8 no strobe", tx_start, 0);
        tick();
        chk("R8 park hold", mode, 2);
        txf_empty = 0; tick();
        chk("R8 resume", mode, 5);
        chk("R8 resume strobe", tx_start, 1);
        txf_empty = 1; pkt_done = 1; tick(); pkt_done = 0;
        chk("R8 park again", mode, 2);
        ce = 0; tick();
        chk("R8 park stop", mode, 1);

        // R9 settle interval
        prim_rx = 1; ce = 1; tick();
        n = 0;
        while (mode == 3 && n < 100) begin
            chk("R9 not listening yet", rx_listen, 0);
            n++; tick();
        end
        chk("R9 settle cycles", n, SETTLE);
        chk("R9 active", mode, 4);
        chk("R9 listen", rx_listen, 1);
        tick(); tick();
        chk("R9 active hold", mode, 4);

        // R10 rx exits
        ce = 0; tick();
        chk("R10 from active", mode, 1);
        chk("R10 listen off", rx_listen, 0);
        ce = 1; tick(); tick();
        chk("R9 settling", mode, 3);
        ce = 0; tick();
        chk("R10 from settle", mode, 1);
        prim_rx = 0;

        // R11 TX time limit
        txf_empty = 0; ce = 1;
        wait_mode(5);
        n = 0;
        while (mode == 5 && n < 100) begin n++; tick(); end
        chk("R11 tx cycles", n, LIMIT);
        chk("R11 abort mode", mode, 1);
        chk("R11 fault", tx_fault, 1);
        tick();
        chk("R11 requalify", mode, 1);
        ce = 0; tick(); tick();
        chk("R11 sticky", tx_fault, 1);

        // R2 power-down from RX and TX
        prim_rx = 1; ce = 1;
        wait_mode(4);
        pwr_up = 0; tick();
        chk("R2 sleep from rx", mode, 0);
        chk("R2 fault cleared", tx_fault, 0);
        chk("R2 listen off", rx_listen, 0);
        pwr_up = 1; tick();
        chk("R2 wake again", mode, 1);
        prim_rx = 0; ce = 0; tick();
        ce = 1;
        wait_mode(5);
        pwr_up = 0; tick();
        chk("R2 sleep from tx", mode, 0);
        tick();
        pwr_up = 1; tick();
        n = 0;
        while (mode == 1 && n < 100) begin n++; tick(); end
        chk("R2 timers reset", n, CEMIN);
        chk("R2 tx after requalify", mode, 5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule